// File: doc/BRIEF.md
# Source Skew Alignment Shifter

This block lines up a stream of 16-bit source words with the destination word grid during a bit-level block copy. It holds a 32-bit staging register. Each accepted source word enters that register from one side, and the side depends on the direction of travel across the source. The block presents a 16-bit window of the register whose offset is a 4-bit skew amount. A fetch sequencer outside the block supplies the words and asks the block two questions. The first is whether an extra word must be read ahead at the start of each line. The second is whether the last read of a line is really needed, or whether the register can simply be shifted.

Software writes a configuration byte. It holds the skew amount in bits 3:0, a read-ahead flag in bit 7 and a tail-skip flag in bit 6. When a transfer starts, this byte is copied into an active copy that governs the whole transfer, and the staging register is cleared at the same time.

Top module: `skew_align`

## Requirements
- R1: While `rst` is high, at every clock edge the configuration byte, the active copy and the staging register clear to zero. Afterwards `cfg_rdata` and `aligned_word` read 0, `tail_fetch_req` reads 1 and `pre_fetch_req` reads 0.
- R2: A `cfg_we` write stores `cfg_wdata & 8'hCF`. Bits 5:4 always read back as 0 on `cfg_rdata`.
- R3: `start` copies the configuration byte into the active copy. If `cfg_we` is high in the same cycle, the newly written (masked) value is the one copied.
- R4: `start` clears the staging register to zero. A `src_load` or `src_shift` in the same cycle is ignored.
- R5: With `dir_neg` low, `src_load` moves the register's low half into its high half and places `src_word` in the low half.
- R6: With `dir_neg` high, `src_load` moves the register's high half into its low half and places `src_word` in the high half.
- R7: `src_shift` without `src_load` moves the register 16 places, toward the high end when `dir_neg` is low and toward the low end when it is high, and fills with zeros. If both are high, `src_load` wins.
- R8: `aligned_word` equals bits [s+15:s] of the staging register, where s is bits 3:0 of the active copy.
- R9: `pre_fetch_req` is high exactly when `line_start` is high and bit 7 of the active copy is set.
- R10: `tail_fetch_req` is high when bit 6 of the active copy is clear. When that bit is set, `tail_fetch_req` is high only if ~(16'hFFFF >> s) is greater than `tail_mask`, compared as unsigned 16-bit values.
- R11: Writes to the configuration byte made without `start` leave the active copy, and with it `aligned_word` and `tail_fetch_req`, unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored configuration byte |
| start | input | 1 | Transfer start: copy configuration, clear staging register |
| line_start | input | 1 | Marks the first fetch slot of a line |
| dir_neg | input | 1 | Source horizontal step is negative |
| src_load | input | 1 | Accept `src_word` into the staging register |
| src_shift | input | 1 | Shift the staging register without a new word |
| src_word | input | 16 | Fetched source word |
| tail_mask | input | 16 | Edge mask of the last word of a line |
| aligned_word | output | 16 | Skewed 16-bit window |
| pre_fetch_req | output | 1 | Read one extra word ahead at this line start |
| tail_fetch_req | output | 1 | The last word of the line must be fetched |

## Verification
A transfer start can land in the same cycle as a configuration write, and also in the same cycle as a word load or shift. Both collisions are forced on purpose, in directed sequences and in a random stream where all three strobes are drawn independently. The bench judges each collision with a behavioural model that applies the write before the copy and lets the clear win over the load. The model is compared with the window output, both fetch decisions and the readback on every cycle. Tail-mask values are also drawn right at the threshold ~(16'hFFFF >> s) and one step on either side of it, so that the unsigned comparison is exercised at its boundary.

// File: rtl/skew_align_pkg.sv
package skew_align_pkg;

    localparam int WORD_W   = 16;
    localparam int SKEW_W   = 4;
    localparam int CFG_W    = 8;
    localparam int SKEW_N   = 1 << SKEW_W;
    localparam int BUF_W    = 2 * WORD_W;
    localparam int PRE_BIT  = CFG_W - 1;
    localparam int SKIP_BIT = CFG_W - 2;
    localparam logic [CFG_W-1:0] CFG_KEEP = CFG_W'((3 << (CFG_W - 2)) | (SKEW_N - 1));

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_CLEAR,
        ST_LOAD,
        ST_SHIFT
    } stage_op_e;

    typedef struct packed {
        logic              pre;
        logic              skip;
        logic [SKEW_W-1:0] amt;
    } act_cfg_t;

    function automatic logic [CFG_W-1:0] cfg_filter(input logic [CFG_W-1:0] v);
        return v & CFG_KEEP;
    endfunction

    // True when the mask of the last word reaches bits the skewed window
    // has not yet been given by earlier words.
    function automatic logic tail_reaches(input logic [SKEW_W-1:0] amt,
                                          input logic [WORD_W-1:0] mask);
        logic [WORD_W-1:0] supplied;
        supplied = ~({WORD_W{1'b1}} >> amt);
        return supplied > mask;
    endfunction

endpackage

// File: rtl/skew_align_cfg.sv
module skew_align_cfg
    import skew_align_pkg::*;
#(
    parameter int CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [CW-1:0] wdata,
    input  logic          start,
    output logic [CW-1:0] rdata,
    output act_cfg_t      act
);
    logic [CW-1:0] reg_q;
    logic [CW-1:0] next_src;

    // A write in the start cycle is what the transfer uses.
    assign next_src = we ? cfg_filter(wdata) : reg_q;
    assign rdata    = reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
            act   <= '0;
        end else begin
            if (we) reg_q <= cfg_filter(wdata);
            if (start) begin
                act.pre  <= next_src[PRE_BIT];
                act.skip <= next_src[SKIP_BIT];
                act.amt  <= next_src[SKEW_W-1:0];
            end
        end
    end
endmodule

// File: rtl/skew_align_stage.sv
module skew_align_stage
    import skew_align_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int BW = BUF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  stage_op_e     op,
    input  logic          dir_neg,
    input  logic [WW-1:0] word,
    output logic [BW-1:0] stage_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            case (op)
                ST_CLEAR: stage_q <= '0;
                ST_LOAD:  stage_q <= dir_neg ? {word, stage_q[BW-1:WW]}
                                             : {stage_q[BW-WW-1:0], word};
                ST_SHIFT: stage_q <= dir_neg ? (stage_q >> WW) : (stage_q << WW);
                default:  stage_q <= stage_q;
            endcase
        end
    end
endmodule

// File: rtl/skew_align_window.sv
module skew_align_window
    import skew_align_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int BW = BUF_W,
    parameter int SW = SKEW_W
) (
    input  logic [BW-1:0] stage,
    input  logic [SW-1:0] amt,
    output logic [WW-1:0] win
);
    localparam int NCAND = 1 << SW;

    logic [WW-1:0] cand [NCAND];

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        assign cand[k] = WW'(stage >> k);
    end

    assign win = cand[amt];
endmodule

// File: rtl/skew_align_fetch.sv
module skew_align_fetch
    import skew_align_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          line_start,
    input  act_cfg_t      act,
    input  logic [WW-1:0] mask,
    output logic          pre_req,
    output logic          tail_req
);
    assign pre_req  = line_start & act.pre;
    assign tail_req = ~act.skip | tail_reaches(act.amt, mask);
endmodule

// File: rtl/skew_align.sv
module skew_align
    import skew_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              start,
    input  logic              line_start,
    input  logic              dir_neg,
    input  logic              src_load,
    input  logic              src_shift,
    input  logic [WORD_W-1:0] src_word,
    input  logic [WORD_W-1:0] tail_mask,
    output logic [WORD_W-1:0] aligned_word,
    output logic              pre_fetch_req,
    output logic              tail_fetch_req
);
    act_cfg_t           act;
    stage_op_e          op;
    logic [BUF_W-1:0]   stage_q;

    // Priority: clear on start, then load, then bare shift.
    always_comb begin
        if (start)          op = ST_CLEAR;
        else if (src_load)  op = ST_LOAD;
        else if (src_shift) op = ST_SHIFT;
        else                op = ST_HOLD;
    end

    skew_align_cfg #(.CW(CFG_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .start (start),
        .rdata (cfg_rdata),
        .act   (act)
    );

    skew_align_stage #(.WW(WORD_W), .BW(BUF_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .dir_neg (dir_neg),
        .word    (src_word),
        .stage_q (stage_q)
    );

    skew_align_window #(.WW(WORD_W), .BW(BUF_W), .SW(SKEW_W)) u_win (
        .stage (stage_q),
        .amt   (act.amt),
        .win   (aligned_word)
    );

    skew_align_fetch #(.WW(WORD_W)) u_fetch (
        .line_start (line_start),
        .act        (act),
        .mask       (tail_mask),
        .pre_req    (pre_fetch_req),
        .tail_req   (tail_fetch_req)
    );
endmodule

// File: rtl/skew_align_chk.sv
module skew_align_chk
    import skew_align_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic              start,
    input logic              line_start,
    input logic              dir_neg,
    input logic              src_load,
    input logic              src_shift,
    input logic [WORD_W-1:0] src_word,
    input logic [WORD_W-1:0] tail_mask,
    input logic [WORD_W-1:0] aligned_word,
    input logic              pre_fetch_req,
    input logic              tail_fetch_req
);
    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk) rst_seen_q <= rst;

    // R1: one clock of reset leaves everything cleared
    always @(negedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clear_R1: assert (cfg_rdata == '0 && aligned_word == '0);
        end
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[SKIP_BIT-1:SKEW_W] == '0);

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (rst)
        start |=> aligned_word == '0);

    assert_pre_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !line_start |-> !pre_fetch_req);

    // R11 / R8: with no start and no stage activity, the window cannot move
    assert_window_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!start && !src_load && !src_shift) |=> $stable(aligned_word));
endmodule

bind skew_align skew_align_chk u_chk (.*);

// File: tb/skew_align_bench.sv
module skew_align_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        start = 1'b0;
    logic        line_start = 1'b0;
    logic        dir_neg = 1'b0;
    logic        src_load = 1'b0;
    logic        src_shift = 1'b0;
    logic [15:0] src_word = '0;
    logic [15:0] tail_mask = '0;
    logic [15:0] aligned_word;
    logic        pre_fetch_req;
    logic        tail_fetch_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model state
    logic [7:0]  m_cfg;
    logic [7:0]  m_act;
    logic [31:0] m_buf;

    always #4 clk = ~clk;

    skew_align u_skew_align (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_win();
        return 16'(m_buf >> m_act[3:0]);
    endfunction

    function automatic logic exp_tail();
        logic [15:0] sup;
        sup = ~(16'hFFFF >> m_act[3:0]);
        return !m_act[6] || (sup > tail_mask);
    endfunction

    task automatic step(input logic r, input logic we, input logic [7:0] wd,
                        input logic st, input logic ls, input logic dn,
                        input logic ld, input logic sh,
                        input logic [15:0] w, input logic [15:0] m);
        @(negedge clk);
        rst = r; cfg_we = we; cfg_wdata = wd; start = st; line_start = ls;
        dir_neg = dn; src_load = ld; src_shift = sh; src_word = w; tail_mask = m;
        #1;
        if (!r) begin
            chk("R2 readback", 32'(cfg_rdata), 32'(m_cfg));
            chk("R3 R4 R5 R6 R7 R8 R11 window", 32'(aligned_word), 32'(exp_win()));
            chk("R9 prefetch", 32'(pre_fetch_req), 32'(ls & m_act[7]));
            chk("R10 tail", 32'(tail_fetch_req), 32'(exp_tail()));
        end
        @(posedge clk);
        if (r) begin
            m_cfg = '0; m_act = '0; m_buf = '0;
        end else begin
            if (st) begin
                m_act = we ? (wd & 8'hCF) : m_cfg;
                m_buf = '0;
            end else if (ld) begin
                m_buf = dn ? {w, m_buf[31:16]} : {m_buf[15:0], w};
            end else if (sh) begin
                m_buf = dn ? (m_buf >> 16) : (m_buf << 16);
            end
            if (we) m_cfg = wd & 8'hCF;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0]  s;
        logic [15:0] thr;
        void'($urandom(32'h5EED));
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: reset state
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h1234);
        chk("R1 rdata", 32'(cfg_rdata), 0);
        chk("R1 window", 32'(aligned_word), 0);
        chk("R1 tail", 32'(tail_fetch_req), 1);
        chk("R1 pre", 32'(pre_fetch_req), 0);

        // R2 masking, R3 plain start
        step(0, 1, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        // R5 forward loads with skew 15
        step(0, 0, 0, 0, 1, 0, 1, 0, 16'h1234, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 16'hABCD, 16'h7FFF);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 16'h8000);
        // R3 start with same-cycle write, R4 start with same-cycle load
        step(0, 1, 8'h74, 1, 0, 1, 1, 0, 16'hFFFF, 0);
        // R6 reverse loads, R7 reverse shift, load wins over shift
        step(0, 0, 0, 0, 0, 1, 1, 1, 16'hC3A5, 16'h0FFF);
        step(0, 0, 0, 0, 0, 1, 1, 0, 16'h5A0F, 16'hF000);
        step(0, 0, 0, 0, 0, 1, 0, 1, 0, 16'hEFFF);
        // R11 write without start must not move the active copy
        step(0, 1, 8'h0B, 0, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            s   = 4'($urandom_range(0, 15));
            thr = ~(16'hFFFF >> s);
            step(i == 300,
                 ($urandom_range(0, 7) == 0),
                 8'($urandom),
                 ($urandom_range(0, 15) == 0),
                 ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 31) == 0) ? ~dir_neg : dir_neg,
                 ($urandom_range(0, 1) == 0),
                 ($urandom_range(0, 3) == 0),
                 16'($urandom),
                 ($urandom_range(0, 1) == 0) ? 16'(thr + 16'($urandom_range(0, 2)) - 16'd1)
                                             : 16'($urandom));
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule